// File: doc/BRIEF.md
# DRAM Power-Down Entry Controller

This block sits beside the command scheduler of a DDR3-class memory controller and decides when the clock-enable line may drop to put the device into power-down. It watches every command the scheduler issues, together with the burst mode and whether any bank is still open. From the command type it works out how many clock cycles must pass before clock enable may go low. A single down-counter keeps the longest requirement still pending. An entry request is granted only in a cycle with no command on the bus, no blocking operation in flight and that counter drained.

On entry the controller reports which power-down flavour the device took. If a bank was open it is active power-down. Otherwise it is precharge power-down, where the DLL is switched off when slow exit is configured. For a set number of cycles after entry the scheduler is told to send only NOP or deselect. A wake request raises clock enable and holds the scheduler off for the exit window. That window is the DLL relock time after a slow exit from precharge power-down, and the short exit time in every other case. Read, write and write-recovery latencies arrive as configuration inputs.

Top module: `pd_entry_ctrl`

## Requirements
- R1: After reset, `cke` is 1, `force_nop` is 0, `dll_off` is 0 and `pd_state` is 0 (idle).
- R2: `cke` falls only at a clock edge where `pd_req` is 1, `cmd_op` is 0 (NOP/deselect), `op_busy` is 0 and every pending command gap has elapsed. When all of these hold, `cke` falls at that edge.
- R3: The command codes are 4=READ and 5=READ with auto-precharge. After either, the earliest edge at which `cke` may fall is `cfg_rl`+5 edges after the command edge.
- R4: The command code is 6=WRITE, and `cmd_chop`=1 selects burst-chop 4 while 0 selects burst length 8. After a write the gap is `cfg_wl`+4+`cfg_wr` for burst length 8 and `cfg_wl`+2+`cfg_wr` for burst-chop 4.
- R5: The command code is 7=WRITE with auto-precharge. Its gap is one cycle longer than a plain write with the same burst mode.
- R6: After codes 1=ACTIVATE, 2=PRECHARGE, 3=REFRESH, 9=MPR access and 10=ZQ calibration, the gap is 1 edge. After code 8=mode register set, the gap is MOD_CYC edges (default 12).
- R7: A later command with a shorter gap never shortens the wait still owed to an earlier command.
- R8: While `op_busy` is 1, `cke` does not fall.
- R9: On entry, `pd_state` becomes 2 (active power-down) if `banks_open` was 1 at the entry edge, and 3 (precharge power-down) otherwise. `dll_off` is 1 only in precharge power-down entered with `cfg_slow_exit`=1.
- R10: `force_nop` is 1 for exactly CPDED_CYC cycles (default 2) after the entry edge. A wake request is not accepted before that window ends.
- R11: An accepted `wake_req` raises `cke` at that edge and enters state 4 (exit) with `force_nop`=1. Exit lasts max(10, ceil(24 ns / clock period)) cycles after a slow precharge power-down, and XP_CYC cycles (default 3) otherwise. The block then returns to idle.
- R12: `pd_state` encodes 0=idle, 1=waiting for entry (`pd_req` high but not granted), 2, 3 and 4 as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 4 | Command issued this cycle (0 = NOP/deselect) |
| cmd_chop | input | 1 | Write burst mode: 1 = burst-chop 4, 0 = burst length 8 |
| banks_open | input | 1 | Some bank is open once in-flight commands complete |
| op_busy | input | 1 | A mode-register, MPR, ZQ, read or write operation is still in flight |
| cfg_rl | input | CFG_W | Read latency in cycles |
| cfg_wl | input | CFG_W | Write latency in cycles |
| cfg_wr | input | CFG_W | Write recovery in cycles |
| cfg_slow_exit | input | 1 | Precharge power-down uses slow exit (DLL off) |
| pd_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| cke | output | 1 | Clock enable to the device |
| force_nop | output | 1 | Scheduler must issue only NOP/deselect |
| dll_off | output | 1 | DLL is off in slow precharge power-down |
| pd_state | output | 3 | Current state code |

## Verification
The entry gap is measured for every command class: read, read with auto-precharge, write and write with auto-precharge in both burst modes, mode-register set, and the one-cycle commands. Each measurement separates one latency formula from its neighbours, and the burst-mode pairs also show that the chop bit only affects writes. A long write followed by a short activate shows whether the counter keeps the maximum or the latest requirement. A busy window held past an expired gap shows that the blocking input is checked on its own. Entries with banks open and closed, under slow and fast exit, tell the two power-down flavours apart and produce the two exit lengths. A wake raised at once after entry shows the NOP hold window.

// File: rtl/pd_entry_pkg.sv
package pd_entry_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_ACT = 4'd1, OP_PRE = 4'd2, OP_REF = 4'd3,
    OP_RD  = 4'd4, OP_RDA = 4'd5, OP_WR  = 4'd6, OP_WRA = 4'd7,
    OP_MRS = 4'd8, OP_MPR = 4'd9, OP_ZQ  = 4'd10
  } pd_op_e;

  typedef enum logic [2:0] {
    PD_IDLE   = 3'd0,
    PD_WAIT   = 3'd1,
    PD_ACTIVE = 3'd2,
    PD_PRECHG = 3'd3,
    PD_EXIT   = 3'd4
  } pd_state_e;

  // Cycles from a command edge to the earliest edge with clock enable low.
  function automatic int unsigned entry_gap(input logic [3:0] op, input logic chop,
                                            input int unsigned rl, input int unsigned wl,
                                            input int unsigned wr, input int unsigned mod_cyc);
    int unsigned burst;
    burst = chop ? 32'd2 : 32'd4;
    case (op)
      OP_NOP:        return 0;
      OP_RD, OP_RDA: return rl + 5;
      OP_WR:         return wl + burst + wr;
      OP_WRA:        return wl + burst + wr + 1;
      OP_MRS:        return mod_cyc;
      default:       return 1;
    endcase
  endfunction

  // DLL relock window: larger of 10 cycles and 24 ns rounded up to cycles.
  function automatic int unsigned dll_exit_cycles(input int unsigned clk_ps);
    int unsigned ns_cyc;
    ns_cyc = (24000 + clk_ps - 1) / clk_ps;
    return (ns_cyc > 10) ? ns_cyc : 10;
  endfunction

endpackage

// File: rtl/pd_gap_timer.sv
module pd_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] gap,
  output logic             drained
);
  logic [CNT_W-1:0] cnt, cnt_dec, gap_m1;

  assign cnt_dec = (cnt == '0) ? '0 : cnt - CNT_W'(1);
  assign gap_m1  = (gap == '0) ? '0 : gap - CNT_W'(1);
  assign drained = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (load && gap_m1 > cnt_dec) cnt <= gap_m1;
    else                               cnt <= cnt_dec;
  end
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_entry_pkg::*;
#(
  parameter int CPDED_CYC = 2,
  parameter int XP_CYC    = 3,
  parameter int XPDLL_CYC = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      entry_grant,
  input  logic      pd_req,
  input  logic      banks_open,
  input  logic      slow_exit,
  input  logic      wake_req,
  output pd_state_e state,
  output logic      cke,
  output logic      force_nop,
  output logic      dll_off,
  output logic      exit_take
);
  localparam int TW = $clog2(CPDED_CYC + XP_CYC + XPDLL_CYC + 1) + 1;

  logic [TW-1:0] tmr, tmr_nxt;
  pd_state_e     nxt;
  logic          slow_q, in_pd;

  assign in_pd     = (state == PD_ACTIVE) || (state == PD_PRECHG);
  assign exit_take = in_pd && wake_req && (tmr <= TW'(1));
  assign cke       = !in_pd;
  assign force_nop = (in_pd && tmr != '0) || (state == PD_EXIT);
  assign dll_off   = (state == PD_PRECHG) && slow_q;

  always_comb begin
    nxt     = state;
    tmr_nxt = (tmr == '0) ? tmr : tmr - TW'(1);
    case (state)
      PD_IDLE, PD_WAIT: begin
        if (entry_grant) begin
          nxt     = banks_open ? PD_ACTIVE : PD_PRECHG;
          tmr_nxt = TW'(CPDED_CYC);
        end else begin
          nxt = pd_req ? PD_WAIT : PD_IDLE;
        end
      end
      PD_ACTIVE, PD_PRECHG: begin
        if (exit_take) begin
          nxt     = PD_EXIT;
          tmr_nxt = (state == PD_PRECHG && slow_q) ? TW'(XPDLL_CYC - 1) : TW'(XP_CYC - 1);
        end
      end
      PD_EXIT: if (tmr == '0) nxt = PD_IDLE;
      default: nxt = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= PD_IDLE;
      tmr    <= '0;
      slow_q <= 1'b0;
    end else begin
      state <= nxt;
      tmr   <= tmr_nxt;
      if (entry_grant && !in_pd) slow_q <= slow_exit && !banks_open;
    end
  end
endmodule

// File: rtl/pd_entry_ctrl.sv
module pd_entry_ctrl
  import pd_entry_pkg::*;
#(
  parameter int CFG_W     = 5,
  parameter int CNT_W     = 8,
  parameter int CLK_PS    = 4000,
  parameter int MOD_CYC   = 12,
  parameter int CPDED_CYC = 2,
  parameter int XP_CYC    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cmd_op,
  input  logic             cmd_chop,
  input  logic             banks_open,
  input  logic             op_busy,
  input  logic [CFG_W-1:0] cfg_rl,
  input  logic [CFG_W-1:0] cfg_wl,
  input  logic [CFG_W-1:0] cfg_wr,
  input  logic             cfg_slow_exit,
  input  logic             pd_req,
  input  logic             wake_req,
  output logic             cke,
  output logic             force_nop,
  output logic             dll_off,
  output logic [2:0]       pd_state
);
  localparam int XPDLL_CYC = int'(dll_exit_cycles(CLK_PS));

  logic             cmd_live, gap_drained, entry_grant, exit_take;
  logic [CNT_W-1:0] cmd_gap;
  pd_state_e        state;

  assign cmd_live    = (cmd_op != OP_NOP);
  assign cmd_gap     = CNT_W'(entry_gap(cmd_op, cmd_chop, 32'(cfg_rl), 32'(cfg_wl),
                                        32'(cfg_wr), MOD_CYC));
  assign entry_grant = pd_req && !cmd_live && gap_drained && !op_busy;

  pd_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_live),
    .gap     (cmd_gap),
    .drained (gap_drained)
  );

  pd_fsm #(.CPDED_CYC(CPDED_CYC), .XP_CYC(XP_CYC), .XPDLL_CYC(XPDLL_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_grant (entry_grant),
    .pd_req      (pd_req),
    .banks_open  (banks_open),
    .slow_exit   (cfg_slow_exit),
    .wake_req    (wake_req),
    .state       (state),
    .cke         (cke),
    .force_nop   (force_nop),
    .dll_off     (dll_off),
    .exit_take   (exit_take)
  );

  assign pd_state = state;
endmodule

// File: rtl/pd_entry_chk.sv
module pd_entry_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd_op,
  input logic       op_busy,
  input logic       banks_open,
  input logic       pd_req,
  input logic       cke,
  input logic       force_nop,
  input logic       dll_off,
  input logic [2:0] pd_state,
  input logic       gap_drained
);
  // R2
  cke_fall_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(pd_req && cmd_op == 4'd0 && gap_drained));

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && cke) |=> cke);

  // R9
  flavour_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (pd_state == ($past(banks_open) ? 3'd2 : 3'd3)));

  // R9
  dll_off_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dll_off |-> (pd_state == 3'd3 && !cke));

  // R10
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> force_nop);

  // R11
  exit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == 3'd4) |-> (cke && force_nop));

  // R12
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_state <= 3'd4);
endmodule

bind pd_entry_ctrl pd_entry_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_op      (cmd_op),
  .op_busy     (op_busy),
  .banks_open  (banks_open),
  .pd_req      (pd_req),
  .cke         (cke),
  .force_nop   (force_nop),
  .dll_off     (dll_off),
  .pd_state    (pd_state),
  .gap_drained (gap_drained)
);

// File: tb/pd_entry_ctrl_test.sv
`timescale 1ns/1ps
module pd_entry_ctrl_test;
  localparam int RL = 11, WL = 8, WR = 12, MODC = 12, HOLD = 2, XPC = 3;
  localparam int XPDLL = ((24 + 4 - 1) / 4 > 10) ? (24 + 4 - 1) / 4 : 10;

  logic       clk = 0, rst_n = 0;
  logic [3:0] cmd_op = 0;
  logic       cmd_chop = 0, banks_open = 0, op_busy = 0, cfg_slow_exit = 0;
  logic       pd_req = 0, wake_req = 0;
  logic [4:0] cfg_rl = 5'(RL), cfg_wl = 5'(WL), cfg_wr = 5'(WR);
  logic       cke, force_nop, dll_off;
  logic [2:0] pd_state;

  int tests = 0, fails = 0, cyc = 0;
  int m_st = 0, m_ready = 0, m_ent = 0, m_xend = 0;
  bit m_slow = 0;
  string cur = "R1";

  pd_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_chop(cmd_chop),
    .banks_open(banks_open), .op_busy(op_busy), .cfg_rl(cfg_rl), .cfg_wl(cfg_wl),
    .cfg_wr(cfg_wr), .cfg_slow_exit(cfg_slow_exit), .pd_req(pd_req),
    .wake_req(wake_req), .cke(cke), .force_nop(force_nop), .dll_off(dll_off),
    .pd_state(pd_state));

  always #2 clk = ~clk;

  function automatic int need(input int op, input bit ch);
    int b = ch ? 2 : 4;
    if (op == 0) return 0;
    if (op == 4 || op == 5) return RL + 5;
    if (op == 6) return WL + WR + b;
    if (op == 7) return WL + WR + b + 1;
    if (op == 8) return MODC;
    return 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_st = 0; m_ready = 0; m_slow = 0;
    end else begin
      cyc = cyc + 1;
      case (m_st)
        0, 1: if (pd_req && cmd_op == 0 && !op_busy && cyc >= m_ready) begin
                m_st = banks_open ? 2 : 3; m_slow = cfg_slow_exit && !banks_open; m_ent = cyc;
              end else m_st = pd_req ? 1 : 0;
        2, 3: if (wake_req && cyc >= m_ent + HOLD) begin
                m_xend = cyc + ((m_st == 3 && m_slow) ? XPDLL : XPC); m_st = 4;
              end
        default: if (cyc >= m_xend) m_st = 0;
      endcase
      if (cmd_op != 0 && cyc + need(cmd_op, cmd_chop) > m_ready)
        m_ready = cyc + need(cmd_op, cmd_chop);
    end
  end

  always @(negedge clk) if (rst_n && cyc > 0) begin
    check({cur, "/R2 cke"}, cke, (m_st == 2 || m_st == 3) ? 0 : 1);
    check("R12 state", pd_state, m_st);
    check("R10 force_nop", force_nop,
          (m_st == 4 || ((m_st == 2 || m_st == 3) && cyc < m_ent + HOLD)) ? 1 : 0);
    check("R9 dll_off", dll_off, (m_st == 3 && m_slow) ? 1 : 0);
  end

  task automatic leave(input int exp_len, input string tag);
    int n = 0;
    @(negedge clk); pd_req = 0; wake_req = 1;
    while (!cke) @(negedge clk);
    wake_req = 0;
    while (pd_state == 3'd4) begin n++; @(negedge clk); end
    check({tag, " exit length"}, n, exp_len);
  endtask

  task automatic gap_run(input int op, input bit ch, input int exp, input string tag);
    int t0;
    cur = tag;
    @(negedge clk); cmd_op = 4'(op); cmd_chop = ch; pd_req = 1; t0 = cyc + 1;
    @(negedge clk); cmd_op = 0;
    while (cke) @(negedge clk);
    check({tag, " entry gap"}, cyc - t0, exp);
    leave(XPC, "R11");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 cke", cke, 1); check("R1 force_nop", force_nop, 0);
    check("R1 dll_off", dll_off, 0); check("R1 state", pd_state, 0);
    rst_n = 1;

    gap_run(4, 0, RL + 5, "R3");
    gap_run(5, 1, RL + 5, "R3");
    gap_run(6, 0, WL + 4 + WR, "R4");
    gap_run(6, 1, WL + 2 + WR, "R4");
    gap_run(7, 0, WL + 4 + WR + 1, "R5");
    gap_run(7, 1, WL + 2 + WR + 1, "R5");
    gap_run(1, 0, 1, "R6");
    gap_run(2, 0, 1, "R6");
    gap_run(3, 1, 1, "R6");
    gap_run(10, 0, 1, "R6");
    gap_run(8, 0, MODC, "R6");

    // R7: short ACT after a long write keeps the write's wait
    begin
      int t0;
      cur = "R7";
      @(negedge clk); cmd_op = 6; cmd_chop = 0; pd_req = 1; t0 = cyc + 1;
      @(negedge clk); cmd_op = 0;
      repeat (2) @(negedge clk);
      cmd_op = 1;
      @(negedge clk); cmd_op = 0;
      while (cke) @(negedge clk);
      check("R7 entry gap", cyc - t0, WL + 4 + WR);
      leave(XPC, "R11");
    end

    // R8: busy holds entry off after the gap has drained
    begin
      int t0;
      cur = "R8";
      @(negedge clk); cmd_op = 1; pd_req = 1; op_busy = 1;
      @(negedge clk); cmd_op = 0;
      repeat (20) @(negedge clk);
      check("R8 cke while busy", cke, 1);
      check("R12 waiting code", pd_state, 1);
      op_busy = 0; t0 = cyc + 1;
      while (cke) @(negedge clk);
      check("R8 entry after busy", cyc, t0);
      leave(XPC, "R11");
    end

    // R9/R11: precharge power-down with slow exit
    cur = "R9"; cfg_slow_exit = 1; banks_open = 0;
    @(negedge clk); pd_req = 1;
    while (cke) @(negedge clk);
    check("R9 precharge code", pd_state, 3);
    check("R9 dll off slow", dll_off, 1);
    repeat (4) @(negedge clk);
    leave(XPDLL, "R11 slow");

    // R9/R11: active power-down keeps DLL, short exit even with slow mode set
    banks_open = 1;
    @(negedge clk); pd_req = 1;
    while (cke) @(negedge clk);
    check("R9 active code", pd_state, 2);
    check("R9 dll on active", dll_off, 0);
    leave(XPC, "R11 active");

    // R9: precharge power-down with fast exit keeps the DLL on
    banks_open = 0; cfg_slow_exit = 0;
    @(negedge clk); pd_req = 1;
    while (cke) @(negedge clk);
    check("R9 dll on fast", dll_off, 0);
    leave(XPC, "R11 fast");

    // R10: wake raised right after entry waits out the hold window
    begin
      int t_fall;
      cur = "R10";
      @(negedge clk); pd_req = 1;
      while (cke) @(negedge clk);
      t_fall = cyc;
      check("R10 hold at entry", force_nop, 1);
      pd_req = 0; wake_req = 1;
      while (!cke) @(negedge clk);
      wake_req = 0;
      check("R10 low cycles", cyc - t_fall, HOLD);
      while (pd_state != 0) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule